// File: doc/BRIEF.md
# Multirate Repetitive Voltage Controller (one synchronous-frame axis)

This block closes the voltage loop for one axis of a three-phase inverter that works in a rotating reference frame. Two copies run side by side, one for each axis. Each new error sample arrives with a one-cycle strobe. The block combines two correction terms. The first is a stabilising two-tap term that runs on every sample. It weights only the two errors that came before the current one, so the command can be applied one sample late without a loss of phase budget.

The second term is a periodic-disturbance canceller that runs at half the sample rate. Its model has one pole per slow-rate bin over one disturbance period: the denominator is z^(HALF_N) − 1, with HALF_N = 21 slow samples by default. It keeps a circular history of slow-rate errors and a circular history of its own past outputs. Each update adds the gain-weighted error from HALF_N − d slow samples back to its own output from HALF_N slow samples back. Here d is a programmable phase-advance index. All coefficients of the model are 0 or 1, so the only fractional multiply is the gain. Between updates the canceller holds its last value. The block adds the held value to the fast term and saturates the sum into the signed 16-bit modulator command.

Top module: `rep_axis_ctrl`

## Requirements
- R1: A synchronous reset drives `cmd_out` to 0 and `cmd_vld` and `im_step` low, and clears both history buffers, both fast-path error registers and the held canceller value. The first strobe after reset is a canceller update.
- R2: At sample k, the fast term is floor((k1·e(k−1) + k2·e(k−2)) / 2^15), where e(k−1) and e(k−2) are the two previous strobe errors. The error presented with the current strobe has no effect on the command produced for that strobe.
- R3: The canceller advances on alternating strobes: on the 1st, 3rd, 5th and later odd strobes after reset. `im_step` is high together with `cmd_vld` exactly for those strobes.
- R4: At slow update m, the canceller output is u(m) = sat16(floor(kim·es(m−21+d)/2^15) + u(m−21)). Here es is the error sampled at each update strobe, and entries older than reset read as 0.
- R5: The command is sat16(fast term + canceller value), where the canceller value is u(m) on an update strobe and the last held u otherwise.
- R6: Every saturation clamps to the range −32768..32767 and never wraps.
- R7: `cmd_vld` pulses for one clock, in the cycle after each strobe. `cmd_out` changes only in that cycle.
- R8: `k1`, `k2`, `kim` (signed Q1.15) and `adv` are taken as presented on each strobe. An `adv` value of 21 or more acts as 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle strobe marking a new error sample |
| err_in | input | 16 | Signed Q1.15 error sample |
| k1 | input | 16 | Signed Q1.15 weight of e(k−1) |
| k2 | input | 16 | Signed Q1.15 weight of e(k−2) |
| kim | input | 16 | Signed Q1.15 canceller gain |
| adv | input | 5 | Phase-advance index d, in slow samples |
| cmd_out | output | 16 | Signed saturated modulator command |
| cmd_vld | output | 1 | Command-updated pulse |
| im_step | output | 1 | Marks commands on which the canceller advanced |

## Verification
The bench uses three kinds of stimulus. Small random errors with the example gains show whether the error taps line up with e(k−1) and e(k−2), and whether the canceller reads the slot 21 − d updates back. Random full-range gains and advances, with idle gaps of random length between strobes, separate correct strobe sampling and output holding from accidental updates. Extreme gains and errors push both the fast term and the canceller recursion into clamping, which shows saturation apart from wrap-around. A reset in the middle of a run shows whether the slow phase and both histories restart.

// File: rtl/rep_pkg.sv
package rep_pkg;
    // Slow-rate phase: whether the next strobe advances the canceller
    typedef enum logic {
        PH_UPD  = 1'b0,
        PH_HOLD = 1'b1
    } rep_phase_e;
endpackage

// File: rtl/rep_pd_path.sv
module rep_pd_path #(
    parameter int W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  stb,
    input  logic signed [W-1:0]   err,
    input  logic signed [W-1:0]   k1,
    input  logic signed [W-1:0]   k2,
    output logic signed [W+1:0]   pd
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic signed [W-1:0] e1;
        logic signed [W-1:0] e2;
    } pd_st_t;

    pd_st_t st_d, st_q;

    logic signed [PW-1:0] p1, p2;
    logic signed [PW:0]   sum;

    always_comb begin
        p1  = $signed({{W{k1[W-1]}}, k1}) * $signed({{W{st_q.e1[W-1]}}, st_q.e1});
        p2  = $signed({{W{k2[W-1]}}, k2}) * $signed({{W{st_q.e2[W-1]}}, st_q.e2});
        sum = $signed({p1[PW-1], p1}) + $signed({p2[PW-1], p2});
        // floor division by 2^(W-1): keep the upper bits
        pd  = sum[PW:W-1];

        st_d = st_q;
        if (stb) begin
            st_d.e2 = st_q.e1;
            st_d.e1 = err;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rep_im_path.sv
module rep_im_path
    import rep_pkg::*;
#(
    parameter int W      = 16,
    parameter int HALF_N = 21,
    parameter int IDX_W  = $clog2(HALF_N)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  stb,
    input  logic signed [W-1:0]   err,
    input  logic signed [W-1:0]   kim,
    input  logic [IDX_W-1:0]      adv,
    output logic                  upd,
    output logic signed [W-1:0]   u_new,
    output logic signed [W-1:0]   u_hold
);
    localparam int PW   = 2 * W;
    localparam int AW   = PW + 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(HALF_N - 1);
    localparam logic signed [AW-1:0] MAXV = AW'((1 << (W - 1)) - 1);
    localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

    typedef struct packed {
        logic [HALF_N-1:0][W-1:0] ebuf;
        logic [HALF_N-1:0][W-1:0] ubuf;
        logic [IDX_W-1:0]         wr;
        rep_phase_e               ph;
        logic signed [W-1:0]      hold;
    } im_st_t;

    im_st_t st_d, st_q;

    logic [IDX_W-1:0]     dsel;
    logic [IDX_W:0]       rd_raw;
    logic [IDX_W-1:0]     rd;
    logic signed [W-1:0]  e_old;
    logic signed [W-1:0]  u_old;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] acc;

    always_comb begin
        // advance index clamp: d < HALF_N
        dsel   = (adv > LAST) ? LAST : adv;
        rd_raw = {1'b0, st_q.wr} + {1'b0, dsel};
        if (rd_raw >= (IDX_W + 1)'(HALF_N)) begin
            rd_raw = rd_raw - (IDX_W + 1)'(HALF_N);
        end
        rd    = rd_raw[IDX_W-1:0];
        e_old = $signed(st_q.ebuf[rd]);
        u_old = $signed(st_q.ubuf[st_q.wr]);

        prod = $signed({{W{kim[W-1]}}, kim}) * $signed({{W{e_old[W-1]}}, e_old});
        acc  = $signed({{(AW - PW + W - 1){prod[PW-1]}}, prod[PW-1:W-1]})
             + $signed({{(AW - W){u_old[W-1]}}, u_old});
        if (acc > MAXV) begin
            u_new = MAXV[W-1:0];
        end else if (acc < MINV) begin
            u_new = MINV[W-1:0];
        end else begin
            u_new = acc[W-1:0];
        end

        upd  = stb && (st_q.ph == PH_UPD);
        st_d = st_q;
        if (stb) begin
            if (st_q.ph == PH_UPD) begin
                st_d.ebuf[st_q.wr] = err;
                st_d.ubuf[st_q.wr] = u_new;
                st_d.hold          = u_new;
                st_d.wr            = (st_q.wr == LAST) ? '0 : st_q.wr + IDX_W'(1);
                st_d.ph            = PH_HOLD;
            end else begin
                st_d.ph = PH_UPD;
            end
        end
        u_hold = st_q.hold;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            st_q.ph <= PH_UPD;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rep_axis_ctrl.sv
module rep_axis_ctrl #(
    parameter int W      = 16,
    parameter int HALF_N = 21,
    parameter int IDX_W  = $clog2(HALF_N)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  smp_stb,
    input  logic signed [W-1:0]   err_in,
    input  logic signed [W-1:0]   k1,
    input  logic signed [W-1:0]   k2,
    input  logic signed [W-1:0]   kim,
    input  logic [IDX_W-1:0]      adv,
    output logic signed [W-1:0]   cmd_out,
    output logic                  cmd_vld,
    output logic                  im_step
);
    localparam int SW = W + 3;
    localparam logic signed [SW-1:0] MAXV = SW'((1 << (W - 1)) - 1);
    localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

    typedef struct packed {
        logic signed [W-1:0] cmd;
        logic                vld;
        logic                stp;
    } out_st_t;

    out_st_t st_d, st_q;

    logic signed [W+1:0] pd;
    logic                upd;
    logic signed [W-1:0] u_new;
    logic signed [W-1:0] u_hold;
    logic signed [W-1:0] u_cur;
    logic signed [SW-1:0] total;

    rep_pd_path #(.W(W)) i_pd (
        .clk (clk),
        .rst (rst),
        .stb (smp_stb),
        .err (err_in),
        .k1  (k1),
        .k2  (k2),
        .pd  (pd)
    );

    rep_im_path #(.W(W), .HALF_N(HALF_N), .IDX_W(IDX_W)) i_im (
        .clk    (clk),
        .rst    (rst),
        .stb    (smp_stb),
        .err    (err_in),
        .kim    (kim),
        .adv    (adv),
        .upd    (upd),
        .u_new  (u_new),
        .u_hold (u_hold)
    );

    always_comb begin
        u_cur = upd ? u_new : u_hold;
        total = $signed({pd[W+1], pd}) + $signed({{3{u_cur[W-1]}}, u_cur});

        st_d     = st_q;
        st_d.vld = smp_stb;
        st_d.stp = upd;
        if (smp_stb) begin
            if (total > MAXV) begin
                st_d.cmd = MAXV[W-1:0];
            end else if (total < MINV) begin
                st_d.cmd = MINV[W-1:0];
            end else begin
                st_d.cmd = total[W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_out = st_q.cmd;
    assign cmd_vld = st_q.vld;
    assign im_step = st_q.stp;
endmodule

// File: rtl/rep_axis_chk.sv
module rep_axis_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                smp_stb,
    input logic signed [W-1:0] cmd_out,
    input logic                cmd_vld,
    input logic                im_step
);
    logic last_step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_step_q <= 1'b0;
        end else if (cmd_vld) begin
            last_step_q <= im_step;
        end
    end

    // R7: valid pulse only in the cycle after an accepted strobe
    assert_vld_after_stb_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_vld |-> ($past(smp_stb) && !$past(rst)));

    // R7: command held while no valid pulse
    assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !cmd_vld |-> $stable(cmd_out));

    // R3: update flag only accompanies a valid command
    assert_step_with_vld_R3: assert property (@(posedge clk) disable iff (rst)
        im_step |-> cmd_vld);

    // R3: updates alternate, starting with an update after reset
    assert_step_alternates_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_vld |-> (im_step != last_step_q));
endmodule

bind rep_axis_ctrl rep_axis_chk #(.W(W)) u_rep_axis_chk (
    .clk     (clk),
    .rst     (rst),
    .smp_stb (smp_stb),
    .cmd_out (cmd_out),
    .cmd_vld (cmd_vld),
    .im_step (im_step)
);

// File: tb/test_rep_axis_ctrl.sv
module test_rep_axis_ctrl;
    localparam int HN = 21;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_stb = 1'b0;
    logic signed [15:0] err_in = '0, k1 = '0, k2 = '0, kim = '0;
    logic [4:0]  adv = '0;
    logic signed [15:0] cmd_out;
    logic        cmd_vld, im_step;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    longint em [HN];
    longint um [HN];
    int     wr, ph;
    longint e1, e2, uh, last_cmd;

    always #2 clk = ~clk;

    rep_axis_ctrl i_rep_axis_ctrl (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .err_in(err_in),
        .k1(k1), .k2(k2), .kim(kim), .adv(adv),
        .cmd_out(cmd_out), .cmd_vld(cmd_vld), .im_step(im_step)
    );

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < HN; i++) begin
            em[i] = 0;
            um[i] = 0;
        end
        wr = 0; ph = 0; e1 = 0; e2 = 0; uh = 0; last_cmd = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        chk("R1 cmd after reset", cmd_out, 0);
        chk("R1 vld after reset", cmd_vld, 0);
        chk("R1 step after reset", im_step, 0);
    endtask

    // one strobe with error x; gains as currently driven
    task automatic strobe(input longint x, input string tag, input int gap);
        longint pd, un, expc;
        int rd, d, upd;
        err_in  = 16'(x);
        smp_stb = 1'b1;
        pd = ((longint'(k1) * e1) + (longint'(k2) * e2)) >>> 15;
        d  = (int'(adv) > HN - 1) ? HN - 1 : int'(adv);
        if (ph == 0) begin
            rd = (wr + d) % HN;
            un = sat16(((longint'(kim) * em[rd]) >>> 15) + um[wr]);
            em[wr] = x;
            um[wr] = un;
            uh = un;
            wr = (wr + 1) % HN;
            ph = 1;
            upd = 1;
        end else begin
            ph = 0;
            upd = 0;
        end
        expc = sat16(pd + uh);
        e2 = e1;
        e1 = x;
        @(negedge clk);
        smp_stb = 1'b0;
        chk({tag, " cmd"}, cmd_out, expc);
        chk("R7 vld pulse", cmd_vld, 1);
        chk("R3 step flag", im_step, upd);
        last_cmd = expc;
        for (int g = 0; g < gap; g++) begin
            err_in = 16'($urandom);
            @(negedge clk);
            chk("R7 idle vld", cmd_vld, 0);
            chk("R7 idle hold", cmd_out, last_cmd);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        do_reset();

        // example gains, small random errors
        k1 = 16'sd3932; k2 = -16'sd2621; kim = 16'sd32767; adv = 5'd1;
        for (int i = 0; i < 120; i++)
            strobe($signed(16'($urandom_range(0, 4000))) - 2000, "R4 R5 example", i % 3);

        // R2: extreme current error must not touch this strobe's command
        strobe(32767, "R2 current-ignored", 0);
        strobe(-32768, "R2 current-ignored", 0);

        // advance corners
        adv = 5'd0;
        for (int i = 0; i < 50; i++) strobe($signed(16'($urandom)) >>> 3, "R4 adv0", 0);
        adv = 5'd20;
        for (int i = 0; i < 50; i++) strobe($signed(16'($urandom)) >>> 3, "R4 adv20", 1);
        adv = 5'd31;
        for (int i = 0; i < 50; i++) strobe($signed(16'($urandom)) >>> 3, "R8 adv clamp", 0);

        // random gains per block
        for (int b = 0; b < 6; b++) begin
            k1 = 16'($urandom); k2 = 16'($urandom); kim = 16'($urandom);
            adv = 5'($urandom_range(0, 20));
            for (int i = 0; i < 50; i++)
                strobe($signed(16'($urandom)), "R8 random gains", int'($urandom_range(0, 3)));
        end

        // saturation of the fast term and the recursion
        k1 = 16'sd32767; k2 = -16'sd32768; kim = 16'sd32767; adv = 5'd3;
        for (int i = 0; i < 60; i++)
            strobe((i % 2 == 0) ? 32767 : -32768, "R6 saturate", 0);
        k1 = -16'sd32768; k2 = 16'sd32767; kim = -16'sd32768;
        for (int i = 0; i < 60; i++)
            strobe((i % 2 == 0) ? 32767 : -32768, "R6 saturate neg", 0);

        // reset mid-run: histories cleared, first strobe updates
        do_reset();
        k1 = 16'sd3932; k2 = -16'sd2621; kim = 16'sd16384; adv = 5'd2;
        for (int i = 0; i < 60; i++)
            strobe($signed(16'($urandom)) >>> 2, "R1 after mid reset", i % 2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule